// File: doc/BRIEF.md
# Store-Multiple Bus Cycle Sequencer

This block produces the memory-interface signalling for a processor's store-multiple operation. A start strobe captures four things: a 16-bit mask of the registers to store, a base address from the ALU, the current program counter and an instruction-length select. The block then runs one opcode prefetch cycle. After that it runs one word write for each register in the mask, taken from the lowest index to the highest. A combinational read port into the register file gives the write data. The block names the register index and the file returns its contents in the same cycle.

Every bus output is registered. A wait input stretches the current bus cycle for as long as it is high. An abort reported on any write is recorded and does not cut the sequence short. When the last write completes, the block gives a one-cycle completion pulse. In that cycle it also reports the abort status, raises a PC-advance strobe and presents the new program counter value.

Top module: `stm_bus_sequencer`

## Requirements
- R1: After reset, and whenever no sequence is active, bus_req_n is 1, bus_wr is 0, bus_seq is 0, bus_opc_n is 1 and done is 0.
- R2: The cycle after an accepted start is an opcode prefetch. bus_addr is pc + 2L, where L is 4 when half_mode is 0 and 2 when half_mode is 1. bus_wr=0, bus_req_n=0, bus_seq=0 and bus_opc_n=0. bus_size is 2 (word) in word mode and 1 (halfword) in halfword mode.
- R3: The cycle after the prefetch completes is a write to the base address. base_addr, pc and half_mode are sampled together with start. This write has bus_size=2, bus_wr=1 and bus_opc_n=1, and bus_wdata carries the lowest-indexed register in the mask.
- R4: The registers are written in ascending index order. Each write after the first targets the previous write address plus 4.
- R5: bus_seq is 1 on every write except the last one of the sequence, which drives bus_seq=0. A sequence with one register therefore writes with bus_seq=0.
- R6: A mask with n set bits gives exactly n+1 bus cycles, with no internal cycle after the last write. An all-zero mask is handled as a transfer of register 0 alone.
- R7: While wait_in is 1 during an active bus cycle, every bus output and the sequence state hold. The sequence resumes unchanged once wait_in falls.
- R8: abort_in is sampled at the end of each write cycle. An abort does not stop or shorten the sequence. abort_flag is updated in the done cycle with whether any write aborted. It then holds until the next start, which clears it.
- R9: done and pc_adv are high for exactly one cycle, the cycle after the last write completes. In that cycle the bus is idle and pc_next equals the sampled pc + 3L.
- R10: A start that arrives while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (accepted when idle) |
| reg_mask | input | 16 | Registers to store, bit i = register i |
| base_addr | input | 32 | First write address from the ALU |
| pc | input | 32 | Current program counter |
| half_mode | input | 1 | 1 = 2-byte instructions, 0 = 4-byte |
| wait_in | input | 1 | Stretches the current bus cycle |
| abort_in | input | 1 | Memory abort for the current write |
| rf_idx | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data for rf_idx |
| bus_addr | output | 32 | Bus address |
| bus_size | output | 2 | Access size code (1 half, 2 word) |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_wdata | output | 32 | Write data |
| bus_req_n | output | 1 | Memory request, active low |
| bus_seq | output | 1 | Next access is sequential |
| bus_opc_n | output | 1 | Opcode fetch, active low |
| pc_adv | output | 1 | PC advance strobe |
| pc_next | output | 32 | New program counter value |
| done | output | 1 | Sequence complete pulse |
| abort_flag | output | 1 | Some write of the last sequence aborted |

## Verification
The sequence is driven with masks of several shapes: one scattered bit, sparse bits at both ends, adjacent bits in halfword mode, an empty mask and a full mask. Together these separate ascending selection from any other order, single-write from multi-write sequential flagging, and the empty-mask rule from a true one-register list. Runs with wait cycles at two different spacings show whether stalls freeze the bus or lose a write. Aborts on a middle write and on the final write show whether late aborts are captured and whether the status clears on the next start. A start pulse during a running sequence, carrying a different mask, shows whether the block can be restarted mid-flight.

// File: rtl/stm_seq_pkg.sv
package stm_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_STORE = 2'd2
  } phase_t;

  localparam logic [1:0] SZ_NONE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/stm_seq_ffs.sv
// Lowest-set-bit selector: prefix OR marks bits that have a lower set bit.
module stm_seq_ffs #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [W-1:0]  onehot,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [W:0] below;

  assign below[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      assign below[g+1] = below[g] | vec[g];
      assign onehot[g]  = vec[g] & ~below[g];
    end
  endgenerate

  assign any = below[W];

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/stm_seq_fsm.sv
// Sequence state: phase, registers still to store, abort accumulator.
module stm_seq_fsm
  import stm_seq_pkg::*;
#(
  parameter int NREG = 16,
  parameter int IW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [NREG-1:0] reg_mask,
  input  logic            wait_in,
  input  logic            abort_in,
  output logic [IW-1:0]   sel_idx,
  output logic            load_fetch,
  output logic            load_store,
  output logic            first_store,
  output logic            finish,
  output logic            seq_next,
  output logic            abort_total
);
  phase_t          phase;
  logic [NREG-1:0] pending;
  logic [NREG-1:0] pick;
  logic            pending_any;
  logic            abort_acc;
  logic            advance;
  logic            abort_now;

  stm_seq_ffs #(.W(NREG), .IW(IW)) u_ffs (
    .vec    (pending),
    .onehot (pick),
    .idx    (sel_idx),
    .any    (pending_any)
  );

  assign advance     = (phase != PH_IDLE) && !wait_in;
  assign load_fetch  = (phase == PH_IDLE) && start;
  assign load_store  = advance && pending_any;
  assign finish      = advance && (phase == PH_STORE) && !pending_any;
  assign first_store = (phase == PH_FETCH);
  assign seq_next    = |(pending & ~pick);
  assign abort_now   = advance && (phase == PH_STORE) && abort_in;
  assign abort_total = abort_acc | abort_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      pending   <= '0;
      abort_acc <= 1'b0;
    end else if (load_fetch) begin
      phase     <= PH_FETCH;
      pending   <= (reg_mask == '0) ? NREG'(1) : reg_mask;
      abort_acc <= 1'b0;
    end else if (advance) begin
      abort_acc <= abort_total;
      if (load_store) begin
        phase   <= PH_STORE;
        pending <= pending & ~pick;
      end else begin
        phase   <= PH_IDLE;
      end
    end
  end
endmodule

// File: rtl/stm_seq_bus.sv
// Registered memory-interface outputs and address / PC arithmetic.
module stm_seq_bus
  import stm_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_fetch,
  input  logic          load_store,
  input  logic          first_store,
  input  logic          finish,
  input  logic          seq_next,
  input  logic          abort_total,
  input  logic          half_mode,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] base_addr,
  input  logic [DW-1:0] rf_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_req_n,
  output logic          bus_seq,
  output logic          bus_opc_n,
  output logic          done_q,
  output logic          abort_q,
  output logic [AW-1:0] pc_next
);
  localparam logic [AW-1:0] WORD_BYTES = AW'(DW / 8);
  localparam logic [AW-1:0] LEN_WORD   = AW'(4);
  localparam logic [AW-1:0] LEN_HALF   = AW'(2);

  logic [AW-1:0] pc_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] len_q;
  logic [AW-1:0] len_in;

  assign len_in = half_mode ? LEN_HALF : LEN_WORD;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr  <= '0;
      bus_size  <= SZ_NONE;
      bus_wr    <= 1'b0;
      bus_wdata <= '0;
      bus_req_n <= 1'b1;
      bus_seq   <= 1'b0;
      bus_opc_n <= 1'b1;
      done_q    <= 1'b0;
      abort_q   <= 1'b0;
      pc_next   <= '0;
      pc_q      <= '0;
      base_q    <= '0;
      len_q     <= '0;
    end else begin
      done_q <= finish;
      if (load_fetch) begin
        pc_q      <= pc;
        base_q    <= base_addr;
        len_q     <= len_in;
        abort_q   <= 1'b0;
        bus_addr  <= pc + (len_in << 1);
        bus_size  <= half_mode ? SZ_HALF : SZ_WORD;
        bus_wr    <= 1'b0;
        bus_wdata <= '0;
        bus_req_n <= 1'b0;
        bus_seq   <= 1'b0;
        bus_opc_n <= 1'b0;
      end else if (load_store) begin
        bus_addr  <= first_store ? base_q : bus_addr + WORD_BYTES;
        bus_size  <= SZ_WORD;
        bus_wr    <= 1'b1;
        bus_wdata <= rf_rdata;
        bus_req_n <= 1'b0;
        bus_seq   <= seq_next;
        bus_opc_n <= 1'b1;
      end else if (finish) begin
        bus_addr  <= '0;
        bus_size  <= SZ_NONE;
        bus_wr    <= 1'b0;
        bus_wdata <= '0;
        bus_req_n <= 1'b1;
        bus_seq   <= 1'b0;
        bus_opc_n <= 1'b1;
        abort_q   <= abort_total;
        pc_next   <= pc_q + (len_q << 1) + len_q;
      end
    end
  end
endmodule

// File: rtl/stm_bus_sequencer.sv
module stm_bus_sequencer #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [NREG-1:0] reg_mask,
  input  logic [AW-1:0]   base_addr,
  input  logic [AW-1:0]   pc,
  input  logic            half_mode,
  input  logic            wait_in,
  input  logic            abort_in,
  output logic [IW-1:0]   rf_idx,
  input  logic [DW-1:0]   rf_rdata,
  output logic [AW-1:0]   bus_addr,
  output logic [1:0]      bus_size,
  output logic            bus_wr,
  output logic [DW-1:0]   bus_wdata,
  output logic            bus_req_n,
  output logic            bus_seq,
  output logic            bus_opc_n,
  output logic            pc_adv,
  output logic [AW-1:0]   pc_next,
  output logic            done,
  output logic            abort_flag
);
  logic load_fetch;
  logic load_store;
  logic first_store;
  logic finish;
  logic seq_next;
  logic abort_total;
  logic done_q;

  stm_seq_fsm #(.NREG(NREG), .IW(IW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .reg_mask    (reg_mask),
    .wait_in     (wait_in),
    .abort_in    (abort_in),
    .sel_idx     (rf_idx),
    .load_fetch  (load_fetch),
    .load_store  (load_store),
    .first_store (first_store),
    .finish      (finish),
    .seq_next    (seq_next),
    .abort_total (abort_total)
  );

  stm_seq_bus #(.AW(AW), .DW(DW)) u_bus (
    .clk         (clk),
    .rst         (rst),
    .load_fetch  (load_fetch),
    .load_store  (load_store),
    .first_store (first_store),
    .finish      (finish),
    .seq_next    (seq_next),
    .abort_total (abort_total),
    .half_mode   (half_mode),
    .pc          (pc),
    .base_addr   (base_addr),
    .rf_rdata    (rf_rdata),
    .bus_addr    (bus_addr),
    .bus_size    (bus_size),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_req_n   (bus_req_n),
    .bus_seq     (bus_seq),
    .bus_opc_n   (bus_opc_n),
    .done_q      (done_q),
    .abort_q     (abort_flag),
    .pc_next     (pc_next)
  );

  assign done   = done_q;
  assign pc_adv = done_q;
endmodule

// File: rtl/stm_bus_sequencer_chk.sv
module stm_bus_sequencer_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          wait_in,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_req_n,
  input logic          bus_seq,
  input logic          bus_opc_n,
  input logic          done,
  input logic          pc_adv
);
  localparam logic [AW-1:0] WB = AW'(DW / 8);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    bus_req_n |-> (!bus_wr && !bus_seq && bus_opc_n));

  assert_fetch_flags_R2: assert property (@(posedge clk) disable iff (rst)
    (!bus_req_n && !bus_wr) |-> (!bus_seq && !bus_opc_n));

  assert_fetch_then_write_R3: assert property (@(posedge clk) disable iff (rst)
    (!bus_req_n && !bus_wr && !wait_in) |=> (!bus_req_n && bus_wr));

  assert_write_flags_R3: assert property (@(posedge clk) disable iff (rst)
    (!bus_req_n && bus_wr) |-> (bus_size == 2'd2 && bus_opc_n));

  assert_seq_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!bus_req_n && bus_wr && bus_seq && !wait_in) |=>
      (!bus_req_n && bus_wr && bus_addr == $past(bus_addr) + WB));

  assert_wait_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (!bus_req_n && wait_in) |=>
      (!bus_req_n && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_wr)
       && $stable(bus_seq) && $stable(bus_size) && $stable(bus_opc_n)));

  assert_last_done_R9: assert property (@(posedge clk) disable iff (rst)
    (!bus_req_n && bus_wr && !bus_seq && !wait_in) |=> (done && pc_adv && bus_req_n));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind stm_bus_sequencer stm_bus_sequencer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wait_in   (wait_in),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_req_n (bus_req_n),
  .bus_seq   (bus_seq),
  .bus_opc_n (bus_opc_n),
  .done      (done),
  .pc_adv    (pc_adv)
);

// File: tb/sim_stm_bus_sequencer.sv
`timescale 1ns/1ps
module sim_stm_bus_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] reg_mask = '0;
  logic [31:0] base_addr = '0;
  logic [31:0] pc = '0;
  logic        half_mode = 1'b0;
  logic        wait_in = 1'b0;
  logic        abort_in = 1'b0;
  logic [3:0]  rf_idx;
  logic [31:0] rf_rdata;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_req_n;
  logic        bus_seq;
  logic        bus_opc_n;
  logic        pc_adv;
  logic [31:0] pc_next;
  logic        done;
  logic        abort_flag;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] rf_value(input int i);
    return 32'h5A00_0011 + (32'(i) * 32'h0001_0203);
  endfunction

  assign rf_rdata = rf_value(int'(rf_idx));

  stm_bus_sequencer u0 (
    .clk(clk), .rst(rst), .start(start), .reg_mask(reg_mask),
    .base_addr(base_addr), .pc(pc), .half_mode(half_mode),
    .wait_in(wait_in), .abort_in(abort_in), .rf_idx(rf_idx),
    .rf_rdata(rf_rdata), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_req_n(bus_req_n),
    .bus_seq(bus_seq), .bus_opc_n(bus_opc_n), .pc_adv(pc_adv),
    .pc_next(pc_next), .done(done), .abort_flag(abort_flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One store-multiple run; every bus cycle is compared as it completes.
  task automatic run_case(input string name, input logic [15:0] mask,
                          input logic [31:0] base, input logic [31:0] pcv,
                          input logic half, input int wait_every,
                          input int abort_at, input bit poke_start);
    int regs[16];
    int n = 0;
    int recs = 0;
    int writes = 0;
    int cyc = 0;
    bit got_done = 0;
    bit stalled = 0;
    logic [31:0] s_addr, s_data;
    logic [4:0]  s_flags;
    logic [31:0] len = half ? 32'd2 : 32'd4;
    bit exp_abort;
    for (int i = 0; i < 16; i++) if (mask[i]) begin regs[n] = i; n++; end
    if (n == 0) begin regs[0] = 0; n = 1; end
    exp_abort = (abort_at >= 0) && (abort_at < n);

    @(posedge clk); #1;
    start = 1; reg_mask = mask; base_addr = base; pc = pcv; half_mode = half;
    wait_in = 0; abort_in = 0;
    @(posedge clk); #1;
    start = 0; base_addr = ~base; pc = ~pcv; half_mode = ~half;

    while (!got_done && cyc < 200) begin
      wait_in  = (wait_every != 0) && ((cyc % wait_every) == 1);
      abort_in = (abort_at >= 0) && bus_wr && !bus_req_n && (writes == abort_at);
      start    = poke_start && (cyc == 2);
      if (poke_start && cyc == 2) reg_mask = 16'hFFFF;
      @(negedge clk);
      if (stalled)
        chk(s_addr == bus_addr && s_data == bus_wdata &&
            s_flags == {bus_size, bus_wr, bus_seq, bus_opc_n} && !bus_req_n,
            "R7", {name, " frozen bus during wait"}, bus_addr, s_addr);
      stalled = 0;
      if (!bus_req_n && wait_in) begin
        stalled = 1;
        s_addr = bus_addr; s_data = bus_wdata;
        s_flags = {bus_size, bus_wr, bus_seq, bus_opc_n};
      end else if (!bus_req_n) begin
        if (recs == 0) begin
          chk(bus_addr == pcv + 2 * len, "R2", {name, " prefetch addr"},
              bus_addr, pcv + 2 * len);
          chk({bus_size, bus_wr, bus_seq, bus_opc_n} == {(half ? 2'd1 : 2'd2), 3'b000},
              "R2", {name, " prefetch flags"},
              32'({bus_size, bus_wr, bus_seq, bus_opc_n}),
              32'({(half ? 2'd1 : 2'd2), 3'b000}));
        end else if (recs <= n) begin
          int k = recs - 1;
          chk(bus_addr == base + 32'(4 * k), k == 0 ? "R3" : "R4",
              {name, " write addr"}, bus_addr, base + 32'(4 * k));
          chk(bus_wdata == rf_value(regs[k]), k == 0 ? "R3" : "R4",
              {name, " write data order"}, bus_wdata, rf_value(regs[k]));
          chk({bus_size, bus_wr, bus_seq, bus_opc_n} == {2'd2, 1'b1, (k < n - 1), 1'b1},
              "R5", {name, " write flags / sequential"},
              32'({bus_size, bus_wr, bus_seq, bus_opc_n}),
              32'({2'd2, 1'b1, (k < n - 1), 1'b1}));
          writes++;
        end else begin
          chk(0, "R6", {name, " extra bus cycle"}, 32'(recs), 32'(n));
        end
        recs++;
      end
      if (done) begin
        got_done = 1;
        chk(recs == n + 1, "R6", {name, " bus cycle count"}, 32'(recs), 32'(n + 1));
        chk(abort_flag == exp_abort, "R8", {name, " abort status"},
            32'(abort_flag), 32'(exp_abort));
        chk(pc_adv && pc_next == pcv + 3 * len && bus_req_n, "R9",
            {name, " pc advance"}, pc_next, pcv + 3 * len);
        if (poke_start)
          chk(recs == n + 1, "R10", {name, " start ignored while busy"},
              32'(recs), 32'(n + 1));
      end
      @(posedge clk); #1;
      cyc++;
    end
    start = 0; wait_in = 0; abort_in = 0;
    if (!got_done) chk(0, "R9", {name, " done never seen"}, 32'(cyc), 32'(n + 1));
    @(negedge clk);
    chk(!done && !pc_adv && bus_req_n && !bus_wr, "R9", {name, " done is one pulse"},
        32'({done, pc_adv, bus_req_n}), 32'b001);
    chk(abort_flag == exp_abort, "R8", {name, " abort status held"},
        32'(abort_flag), 32'(exp_abort));
  endtask

  task automatic check_reset;
    @(negedge clk);
    chk(bus_req_n && !bus_wr && !bus_seq && bus_opc_n && !done, "R1", "reset idle bus",
        32'({bus_req_n, bus_wr, bus_seq, bus_opc_n, done}), 32'b10010);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check_reset();
    run_case("single",     16'h0010, 32'h0000_2000, 32'h0000_1000, 1'b0, 0, -1, 0);
    run_case("sparse",     16'h8421, 32'h0000_4100, 32'h0000_0800, 1'b0, 0, -1, 0);
    run_case("halfword",   16'h0006, 32'h0001_0000, 32'h0000_0302, 1'b1, 0, -1, 0);
    run_case("empty_mask", 16'h0000, 32'h0000_0040, 32'h0000_0100, 1'b0, 0, -1, 0);
    run_case("full_wait",  16'hFFFF, 32'h0000_8000, 32'h0000_0400, 1'b0, 3, -1, 0);
    run_case("abort_mid",  16'h00F0, 32'h0000_3000, 32'h0000_0500, 1'b0, 0, 1, 0);
    run_case("abort_last", 16'h0124, 32'h0000_3400, 32'h0000_0600, 1'b1, 2, 2, 0);
    run_case("abort_clr",  16'h0003, 32'h0000_3800, 32'h0000_0700, 1'b0, 0, -1, 0);
    run_case("start_poke", 16'h0300, 32'h0000_5000, 32'h0000_0900, 1'b0, 0, -1, 1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule